// File: doc/BRIEF.md
# Serial-Configured Fault Injection Controller

This block sits between a set of functional signals and the logic that consumes them, and lets a test engineer corrupt exactly one of those signals on purpose. The engineer shifts a configuration word into an on-chip shift register one bit per clock. The word names the target node, what to do to it (hold it low, hold it high, or flip it) and when to do it (every cycle, once, or once every PERIOD cycles). An update strobe copies the shifted word into the active configuration. A decoder turns the node index into a one-hot select. A forcing cell on each instrumented node then either passes the functional value or substitutes the faulty one.

While no fault is active, the path from each functional input to its output is purely combinational, so the instrumented nodes see no added latency. Because shifting and activation are separate steps, the next fault can be loaded while the current one keeps running.

Top module: `fault_inject_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first update strobe, every node output equals its functional input.
- R2: On each clock with shift_en high, the configuration shift register moves left by one and takes sdi into its lowest bit. A word of IDX_W+4 bits is therefore loaded most significant bit first, and it holds the node index in bits [IDX_W+3:4], the fault kind in bits [3:2] and the timing in bits [1:0].
- R3: Shifting does not change the active fault. The clock edge on which update is high copies the shift register into the active configuration, and that configuration takes effect from the next cycle.
- R4: The fault kind is encoded as 00 none, 01 force to 0, 10 force to 1, 11 invert the functional value. A kind of 00 leaves every output equal to its input.
- R5: Timing 00 applies the fault on every cycle until the next update.
- R6: Timing 01 applies the fault only in the first cycle after the update strobe.
- R7: Timing 10 applies the fault in the first cycle after the update and again every PERIOD cycles after that (PERIOD defaults to 5).
- R8: Timing 11 is reserved and applies no fault.
- R9: At most one node is affected at any time. Every node other than the selected one passes its input unchanged, and a node index of NUM_NODES or more (default 10) disables injection.
- R10: The node outputs respond in the same cycle to changes on func_in, with no register in the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial configuration data |
| shift_en | input | 1 | Shift one configuration bit in this cycle |
| update | input | 1 | Copy the shifted word into the active configuration |
| func_in | input | NUM_NODES | Functional node values |
| node_out | output | NUM_NODES | Node values after fault forcing |

## Verification
The assertions check on every cycle that the select stays one-hot or empty and that every unselected node matches its input. They also check that the active configuration holds between update strobes, that a kind of none or a reserved timing passes all nodes, that the periodic phase stays in range, and that a single-cycle fault never lasts two cycles. Only the bench scenarios can show that the serial bit order lands each field in the right place, that each kind produces the right value on the right node, that the periodic fault recurs exactly PERIOD cycles apart, and that outputs follow input changes within the same cycle.

// File: rtl/fi_pkg.sv
package fi_pkg;

  typedef enum logic [1:0] {
    K_NONE   = 2'b00,
    K_STUCK0 = 2'b01,
    K_STUCK1 = 2'b10,
    K_INVERT = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    T_PERM     = 2'b00,
    T_PULSE    = 2'b01,
    T_PERIODIC = 2'b10,
    T_RESERVED = 2'b11
  } timing_e;

  localparam int KIND_LSB   = 2;
  localparam int TIMING_LSB = 0;
  localparam int FIELD_BITS = 4;

  // Value driven onto a node when its fault is active.
  function automatic logic apply_fault(input kind_e kind, input logic din);
    logic r;
    case (kind)
      K_STUCK0: r = 1'b0;
      K_STUCK1: r = 1'b1;
      K_INVERT: r = ~din;
      default:  r = din;
    endcase
    return r;
  endfunction

  // Whether the timing rule allows the fault in the current cycle.
  function automatic logic timing_allows(input timing_e t, input logic fresh,
                                         input logic phase_zero);
    logic r;
    case (t)
      T_PERM:     r = 1'b1;
      T_PULSE:    r = fresh;
      T_PERIODIC: r = phase_zero;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fi_config_reg.sv
module fi_config_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi,
  input  logic             shift_en,
  input  logic             update,
  output logic [CFG_W-1:0] active_cfg
);

  logic [CFG_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= {shift_q[CFG_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_cfg <= '0;
    end else if (update) begin
      active_cfg <= shift_q;
    end
  end

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(active_cfg)); // R3

endmodule

// File: rtl/fi_timing.sv
module fi_timing
  import fi_pkg::*;
#(
  parameter int PERIOD = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    update,
  input  timing_e timing,
  output logic    fire
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             fresh_q;
  logic [CNT_W-1:0] phase_q;
  logic             phase_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      phase_q <= '0;
    end else begin
      fresh_q <= update;
      if (update || phase_q == LAST) begin
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_zero = (phase_q == '0);
  assign fire       = timing_allows(timing, fresh_q, phase_zero);

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R7

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (timing == T_PULSE && fire && !update) |=> !fire); // R6

  AST_PERM_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (timing == T_PERM) |-> fire); // R5

endmodule

// File: rtl/fi_decoder.sv
module fi_decoder #(
  parameter int NUM_NODES = 10,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 enable,
  output logic [NUM_NODES-1:0] sel
);

  for (genvar g = 0; g < NUM_NODES; g++) begin : g_dec
    assign sel[g] = enable && (idx == IDX_W'(g));
  end

  AST_ONE_NODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R9

  AST_OUT_OF_RANGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idx) >= NUM_NODES) |-> (sel == '0)); // R9

endmodule

// File: rtl/fi_force_cell.sv
module fi_force_cell
  import fi_pkg::*;
(
  input  logic  sel,
  input  kind_e kind,
  input  logic  din,
  output logic  dout
);

  assign dout = sel ? apply_fault(kind, din) : din;

endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
  import fi_pkg::*;
#(
  parameter int NUM_NODES = 10,
  parameter int IDX_W     = 4,
  parameter int PERIOD    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdi,
  input  logic                 shift_en,
  input  logic                 update,
  input  logic [NUM_NODES-1:0] func_in,
  output logic [NUM_NODES-1:0] node_out
);

  localparam int CFG_W = IDX_W + FIELD_BITS;

  logic [CFG_W-1:0]     active_cfg;
  logic [IDX_W-1:0]     node_idx;
  kind_e                kind;
  timing_e              timing;
  logic                 fire;
  logic                 inject_on;
  logic [NUM_NODES-1:0] node_sel;

  fi_config_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdi        (sdi),
    .shift_en   (shift_en),
    .update     (update),
    .active_cfg (active_cfg)
  );

  assign node_idx = active_cfg[CFG_W-1:FIELD_BITS];
  assign kind     = kind_e'(active_cfg[KIND_LSB+1:KIND_LSB]);
  assign timing   = timing_e'(active_cfg[TIMING_LSB+1:TIMING_LSB]);

  fi_timing #(.PERIOD(PERIOD)) u_tim (
    .clk    (clk),
    .rst_n  (rst_n),
    .update (update),
    .timing (timing),
    .fire   (fire)
  );

  assign inject_on = fire && (kind != K_NONE);

  fi_decoder #(.NUM_NODES(NUM_NODES), .IDX_W(IDX_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (node_idx),
    .enable (inject_on),
    .sel    (node_sel)
  );

  for (genvar g = 0; g < NUM_NODES; g++) begin : g_cell
    fi_force_cell u_cell (
      .sel  (node_sel[g]),
      .kind (kind),
      .din  (func_in[g]),
      .dout (node_out[g])
    );
  end

  AST_UNSELECTED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((func_in ^ node_out) & ~node_sel) == '0); // R9

  AST_NONE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_NONE) |-> (node_out == func_in)); // R4

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (timing == T_RESERVED) |-> (node_out == func_in)); // R8

endmodule

// File: tb/fault_inject_ctrl_test.sv
`timescale 1ns/1ps
module fault_inject_ctrl_test;

  localparam int N  = 10;
  localparam int IW = 4;
  localparam int P  = 5;
  localparam int CW = IW + 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdi = 1'b0;
  logic         shift_en = 1'b0;
  logic         update = 1'b0;
  logic [N-1:0] func_in = '0;
  logic [N-1:0] node_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_inject_ctrl #(.NUM_NODES(N), .IDX_W(IW), .PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en),
    .update(update), .func_in(func_in), .node_out(node_out)
  );

  // Reference model state, advanced from the requirements at each edge.
  logic [CW-1:0] m_sh, m_cfg;
  int            m_since;
  bit            m_fresh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh <= '0; m_cfg <= '0; m_since <= 0; m_fresh <= 0;
    end else begin
      if (shift_en) m_sh <= {m_sh[CW-2:0], sdi};
      if (update) begin
        m_cfg <= m_sh; m_since <= 0; m_fresh <= 1;
      end else begin
        m_since <= m_since + 1; m_fresh <= 0;
      end
    end
  end

  function automatic logic [N-1:0] expect_out(input logic [N-1:0] f);
    int idx;
    logic [1:0] k, t;
    bit on;
    logic [N-1:0] r;
    idx = int'(m_cfg[CW-1:4]);
    k = m_cfg[3:2];
    t = m_cfg[1:0];
    case (t)
      2'b00: on = 1;
      2'b01: on = m_fresh;
      2'b10: on = (m_since % P) == 0;
      default: on = 0;
    endcase
    r = f;
    if (rst_n && on && idx < N && k != 2'b00) begin
      if (k == 2'b01) r[idx] = 1'b0;
      else if (k == 2'b10) r[idx] = 1'b1;
      else r[idx] = ~f[idx];
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] mk(input int idx, input logic [1:0] k,
                                       input logic [1:0] t);
    return {IW'(idx), k, t};
  endfunction

  task automatic cyc(input logic s, input logic sh, input logic up,
                     input logic [N-1:0] f, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    sdi = s; shift_en = sh; update = up; func_in = f;
    #1;
    e = expect_out(f);
    checks++;
    if (node_out !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, node_out, e);
    end
  endtask

  task automatic load(input logic [CW-1:0] w, input string tag);
    for (int i = CW - 1; i >= 0; i--) cyc(w[i], 1'b1, 1'b0, N'($urandom), "R3");
    cyc(1'b0, 1'b0, 1'b1, N'($urandom), tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, N'($urandom), tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    // R1: during and right after reset
    run(3, "R1");
    @(negedge clk); rst_n = 1'b1;
    run(3, "R1");
    // R2 / R5: stuck-1 on node 3, permanent
    load(mk(3, 2'b10, 2'b00), "R2");
    run(4, "R5");
    cyc(0, 0, 0, '0, "R2");
    // R4: stuck-0 on node 7 and invert on node 0
    load(mk(7, 2'b01, 2'b00), "R4");
    cyc(0, 0, 0, '1, "R4");
    run(3, "R4");
    load(mk(0, 2'b11, 2'b00), "R4");
    run(4, "R4");
    // R3: shifting a new word while the invert stays active
    for (int i = CW - 1; i >= 0; i--) cyc(mk(9, 2'b10, 2'b00) >> i, 1'b1, 1'b0, '0, "R3");
    run(3, "R3");
    // R6: single-cycle stuck-1 on node 5
    load(mk(5, 2'b10, 2'b01), "R6");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, '0, "R6");
    // R7: periodic invert on node 2
    load(mk(2, 2'b11, 2'b10), "R7");
    for (int i = 0; i < 14; i++) cyc(0, 0, 0, '0, "R7");
    // R8: reserved timing
    load(mk(1, 2'b10, 2'b11), "R8");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, "R8");
    // R9: index beyond range, then last valid index
    load(mk(12, 2'b10, 2'b00), "R9");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, "R9");
    load(mk(N - 1, 2'b10, 2'b00), "R9");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, "R9");
    // R10: random traffic, outputs follow func_in in the same cycle
    for (int i = 0; i < 4000; i++)
      cyc(1'($urandom), ($urandom % 4) != 0, ($urandom % 12) == 0, N'($urandom), "R10");
    finish_up();
  end

endmodule